// File: doc/BRIEF.md
# Multiword DMA Host Strobe Sequencer

This block is the host side of a parallel disk interface running multiword DMA. Once a transfer is started with a word count and a direction, it waits for the device's DMA request. It then asserts the acknowledge line and issues one read or write strobe per 16-bit word. Write words come from a host buffer over a valid/ready handshake and are driven onto the shared data bus. Read words are latched from the bus at the strobe's trailing edge and offered to the host buffer over a second valid/ready handshake.

Every timing figure comes from a per-mode table in nanoseconds. It is turned into clock counts by rounding up against the `CLK_NS` parameter. Three speed modes are supported. The strobe-active phase is held to its own minimum. The recovery phase takes the largest of the direction-dependent recovery minimum, the data hold, the acknowledge hold, the request settling window, and whatever is still missing from the per-mode total cycle minimum. The device request is looked at only when recovery has fully elapsed. If the request is low at that point, the current burst closes and acknowledge is released. The sequencer then waits for the request to return and continues with the remaining words.

State machine states:
- `ST_IDLE` (no transfer).
- `ST_WAIT_REQ` (waiting for the request and a buffer slot).
- `ST_SETUP` (acknowledge asserted, address and write data settling before the strobe).
- `ST_ACTIVE` (strobe low).
- `ST_RECOVER` (strobe high between words).
- `ST_HOLD` (acknowledge kept after the last strobe).

Transitions:
- IDLE→WAIT_REQ on a start with a non-zero count.
- WAIT_REQ→SETUP when the request is high and a word or read slot is available.
- SETUP→ACTIVE when setup expires.
- ACTIVE→HOLD after the final word.
- ACTIVE→RECOVER otherwise.
- RECOVER→WAIT_REQ when the request is low at the end of recovery.
- RECOVER→SETUP for the next write word.
- RECOVER→ACTIVE for the next read word.
- HOLD→IDLE when the hold expires.

Top module: `mwdma_host`

## Requirements
- R1: After reset the block is idle: `busy` low, acknowledge, both strobes and `dd_oe` negated, `rd_valid` low. A `start` pulse while idle with a non-zero `word_count` begins a transfer of exactly that many strobes, and `busy` stays high until acknowledge is released after the last one. A `start` with `word_count` zero is ignored.
- R2: Every strobe stays low for ceil(Tact/CLK_NS) cycles. Tact is 215, 80 or 70 ns for modes 0, 1 and 2.
- R3: On reads, the strobe-high gap between consecutive words is the largest of four values: ceil(Trec_rd), ceil(Treq_rd), ceil(Tackh), and ceil(Tcyc) − ceil(Tact). Trec_rd is 50/50/25 ns, Treq_rd is 120/40/35 ns, Tackh is 20/5/5 ns and Tcyc is 480/150/120 ns.
- R4: On writes, the strobe-high gap is ceil(Twsu) + rec. Twsu is 100/30/20 ns. rec is the largest of five values: ceil(Trec_wr), ceil(Treq_wr), ceil(Tackh), ceil(Twh), and ceil(Tcyc) − ceil(Tact) − ceil(Twsu). Trec_wr is 215/50/25 ns, Treq_wr is 40/40/35 ns and Twh is 20/15/10 ns.
- R5: From acknowledge assertion to the first strobe of each burst takes ceil(Tsel) cycles on reads and max(ceil(Tsel), ceil(Twsu)) cycles on writes. Tsel is 50/30/25 ns.
- R6: After the final strobe rises, acknowledge stays asserted for ceil(Tackh) cycles on reads and max(ceil(Tackh), ceil(Twh)) cycles on writes.
- R7: Mode code 3 produces the same timing as mode 0. Modes are encoded 0, 1 and 2 on `mode[1:0]`.
- R8: Write words appear on `dd_out` in buffer order, stay unchanged while the write strobe is low, and `dd_oe` is high only while acknowledge is asserted during a write transfer.
- R9: Read data is captured from `dd_in` on the edge where the read strobe rises. It is held on `rd_data` with `rd_valid` until `rd_ready`. No further read strobe starts while an unaccepted word is pending.
- R10: The request is sampled only at the end of recovery, so a low pulse inside recovery has no effect. A low request at that point releases acknowledge, and the transfer resumes with a new setup phase once the request returns.
- R11: At most one strobe is low at any time, only the one matching the direction, and only while acknowledge is asserted.
- R12: `cs_n` is held at 2'b11 (both selects negated), as multiword DMA requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| dir_write | input | 1 | 1 = host-to-device writes, 0 = reads |
| mode | input | 2 | Speed mode 0..2 (3 behaves as 0) |
| word_count | input | WCNT_W | Number of words to move |
| busy | output | 1 | Transfer in progress |
| wr_data | input | DATA_W | Next write word from the host buffer |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Write word taken this cycle when valid |
| rd_data | output | DATA_W | Latched read word |
| rd_valid | output | 1 | Read word pending |
| rd_ready | input | 1 | Host buffer accepts the read word |
| dmarq | input | 1 | Device DMA request |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cs_n | output | 2 | Chip selects, held negated |
| dd_in | input | DATA_W | Data bus input from the pads |
| dd_out | output | DATA_W | Data bus output to the pads |
| dd_oe | output | 1 | Data bus output enable |

## Verification
The bench builds the block with `CLK_NS` = 20 to match its 50 MHz clock, and with a 16-bit data path and an 8-bit word count. At that period the rounding turns every mode into distinct small cycle counts. The total-cycle stretch is visible on mode 1 reads (gap 4 against a recovery minimum of 3). The write recovery in mode 0 is instead set by the recovery minimum. The bench sweeps all four mode codes in both directions for one-word and five-word transfers, and measures every strobe width, gap, lead and tail against its own arithmetic. Separate runs cover request drops inside and at the end of recovery, read back-pressure and a zero count.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

    // Width of the phase counters; covers CLK_NS down to 1 ns (480 cycles).
    localparam int PH_W = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER,
        ST_HOLD
    } state_e;

    typedef enum int {
        TP_CYCLE,
        TP_ACTIVE,
        TP_RECOV_RD,
        TP_RECOV_WR,
        TP_WSETUP,
        TP_WHOLD,
        TP_ACKHOLD,
        TP_SELSETUP,
        TP_REQ_RD,
        TP_REQ_WR
    } tparam_e;

    // Phase lengths in clock cycles (each at least 1).
    typedef struct packed {
        logic [PH_W-1:0] first_pre;
        logic [PH_W-1:0] next_pre;
        logic [PH_W-1:0] act;
        logic [PH_W-1:0] rec;
        logic [PH_W-1:0] hold;
    } phase_t;

    // Nanosecond figure of one timing term for speed mode m (0..2).
    function automatic int ns_of(tparam_e p, int m);
        int v0, v1, v2;
        case (p)
            TP_CYCLE:    begin v0 = 480; v1 = 150; v2 = 120; end
            TP_ACTIVE:   begin v0 = 215; v1 = 80;  v2 = 70;  end
            TP_RECOV_RD: begin v0 = 50;  v1 = 50;  v2 = 25;  end
            TP_RECOV_WR: begin v0 = 215; v1 = 50;  v2 = 25;  end
            TP_WSETUP:   begin v0 = 100; v1 = 30;  v2 = 20;  end
            TP_WHOLD:    begin v0 = 20;  v1 = 15;  v2 = 10;  end
            TP_ACKHOLD:  begin v0 = 20;  v1 = 5;   v2 = 5;   end
            TP_SELSETUP: begin v0 = 50;  v1 = 30;  v2 = 25;  end
            TP_REQ_RD:   begin v0 = 120; v1 = 40;  v2 = 35;  end
            default:     begin v0 = 40;  v1 = 40;  v2 = 35;  end
        endcase
        return (m == 0) ? v0 : (m == 1) ? v1 : v2;
    endfunction

    function automatic int clk_ceil(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mwdma_timing.sv
module mwdma_timing
    import mwdma_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic [1:0] mode,
    input  logic       wr,
    output phase_t     tm
);

    phase_t tbl [3][2];

    for (genvar m = 0; m < 3; m++) begin : g_mode
        for (genvar d = 0; d < 2; d++) begin : g_dir
            localparam int CYC  = clk_ceil(ns_of(TP_CYCLE, m), CLK_NS);
            localparam int ACT  = clk_ceil(ns_of(TP_ACTIVE, m), CLK_NS);
            localparam int SEL  = clk_ceil(ns_of(TP_SELSETUP, m), CLK_NS);
            localparam int WSU  = clk_ceil(ns_of(TP_WSETUP, m), CLK_NS);
            localparam int WH   = clk_ceil(ns_of(TP_WHOLD, m), CLK_NS);
            localparam int ACKH = clk_ceil(ns_of(TP_ACKHOLD, m), CLK_NS);
            localparam int RMIN = clk_ceil(ns_of(d ? TP_RECOV_WR : TP_RECOV_RD, m), CLK_NS);
            localparam int REQW = clk_ceil(ns_of(d ? TP_REQ_WR : TP_REQ_RD, m), CLK_NS);
            localparam int PRE_N = d ? WSU : 0;
            localparam int PRE_F = d ? imax(SEL, WSU) : SEL;
            // Recovery absorbs whatever the total cycle minimum still lacks.
            localparam int REC  = imax(imax(RMIN, REQW),
                                       imax(imax(ACKH, d ? WH : 1), CYC - ACT - PRE_N));
            localparam int HLD  = d ? imax(ACKH, WH) : ACKH;

            assign tbl[m][d] = '{
                first_pre: PH_W'(PRE_F),
                next_pre:  PH_W'(imax(PRE_N, 1)),
                act:       PH_W'(ACT),
                rec:       PH_W'(REC),
                hold:      PH_W'(HLD)
            };
        end
    end

    always_comb begin
        unique case (mode)
            2'd1:    tm = tbl[1][wr];
            2'd2:    tm = tbl[2][wr];
            default: tm = tbl[0][wr];
        endcase
    end

endmodule

// File: rtl/mwdma_phase_cnt.sv
module mwdma_phase_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/mwdma_host.sv
module mwdma_host
    import mwdma_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int DATA_W = 16,
    parameter int WCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_write,
    input  logic [1:0]        mode,
    input  logic [WCNT_W-1:0] word_count,
    output logic              busy,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    input  logic              dmarq,
    output logic              dmack_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic [1:0]        cs_n,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe
);

    state_e              st, st_nx;
    phase_t              tm;
    logic                ld, cnt_zero;
    logic [PH_W-1:0]     ld_val;
    logic [1:0]          mode_q;
    logic                dir_q;
    logic [WCNT_W-1:0]   remain;
    logic [DATA_W-1:0]   wdata_q, rdata_q;
    logic                rvalid_q;
    logic                start_ok, rd_slot, last_word, ack_on;

    assign start_ok  = start && (word_count != '0);
    assign rd_slot   = !rvalid_q || rd_ready;
    assign last_word = (remain == WCNT_W'(1));

    mwdma_timing #(.CLK_NS(CLK_NS)) u_timing (
        .mode (mode_q),
        .wr   (dir_q),
        .tm   (tm)
    );

    mwdma_phase_cnt #(.W(PH_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .zero     (cnt_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state and phase counter loads
    always_comb begin
        st_nx  = st;
        ld     = 1'b0;
        ld_val = '0;
        unique case (st)
            ST_IDLE: begin
                if (start_ok) st_nx = ST_WAIT_REQ;
            end
            ST_WAIT_REQ: begin
                if (dmarq && (dir_q ? wr_valid : rd_slot)) begin
                    st_nx  = ST_SETUP;
                    ld     = 1'b1;
                    ld_val = tm.first_pre - PH_W'(1);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    st_nx  = ST_ACTIVE;
                    ld     = 1'b1;
                    ld_val = tm.act - PH_W'(1);
                end
            end
            ST_ACTIVE: begin
                if (cnt_zero) begin
                    ld = 1'b1;
                    if (last_word) begin
                        st_nx  = ST_HOLD;
                        ld_val = tm.hold - PH_W'(1);
                    end else begin
                        st_nx  = ST_RECOVER;
                        ld_val = tm.rec - PH_W'(1);
                    end
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) begin
                    if (!dmarq) begin
                        st_nx = ST_WAIT_REQ;
                    end else if (dir_q) begin
                        if (wr_valid) begin
                            st_nx  = ST_SETUP;
                            ld     = 1'b1;
                            ld_val = tm.next_pre - PH_W'(1);
                        end
                    end else if (rd_slot) begin
                        st_nx  = ST_ACTIVE;
                        ld     = 1'b1;
                        ld_val = tm.act - PH_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        ack_on   = (st == ST_SETUP) || (st == ST_ACTIVE) ||
                   (st == ST_RECOVER) || (st == ST_HOLD);
        busy     = (st != ST_IDLE);
        dmack_n  = !ack_on;
        dior_n   = !((st == ST_ACTIVE) && !dir_q);
        diow_n   = !((st == ST_ACTIVE) && dir_q);
        dd_oe    = ack_on && dir_q;
        cs_n     = 2'b11;
        wr_ready = dir_q && dmarq &&
                   ((st == ST_WAIT_REQ) || ((st == ST_RECOVER) && cnt_zero));
        rd_valid = rvalid_q;
        rd_data  = rdata_q;
        dd_out   = wdata_q;
    end

    // Transfer context and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            dir_q    <= 1'b0;
            remain   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if ((st == ST_IDLE) && start_ok) begin
                mode_q <= mode;
                dir_q  <= dir_write;
                remain <= word_count;
            end
            if ((st == ST_ACTIVE) && cnt_zero) remain <= remain - WCNT_W'(1);
            if (wr_valid && wr_ready) wdata_q <= wr_data;
            if ((st == ST_ACTIVE) && cnt_zero && !dir_q) begin
                rdata_q  <= dd_in;
                rvalid_q <= 1'b1;
            end else if (rvalid_q && rd_ready) begin
                rvalid_q <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    assert_strobe_needs_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> !dmack_n);

    assert_lead_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dior_n) || $fell(diow_n)) |-> !$past(dmack_n));

    assert_oe_only_write_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dd_oe |-> (!dmack_n && dior_n));

    assert_wdata_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!diow_n && !$past(diow_n)) |-> $stable(dd_out));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_pause_on_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dmack_n) && busy) |-> !$past(dmarq));

    assert_idle_releases_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> dmack_n);

endmodule

// File: tb/tb_mwdma_host.sv
module tb_mwdma_host;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_write = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [7:0]  word_count = 8'd0;
    logic        busy;
    logic [15:0] wr_data;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic        dmarq = 1'b1;
    logic        dmack_n, dior_n, diow_n, dd_oe;
    logic [1:0]  cs_n;
    logic [15:0] dd_in, dd_out;

    always #10 clk = ~clk;

    mwdma_host #(.CLK_NS(CLK_NS), .DATA_W(16), .WCNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .mode(mode), .word_count(word_count), .busy(busy),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .dmarq(dmarq), .dmack_n(dmack_n), .dior_n(dior_n), .diow_n(diow_n),
        .cs_n(cs_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [15:0] wpat(int i);
        return 16'hA500 ^ 16'(i * 291);
    endfunction
    function automatic logic [15:0] rpat(int i);
        return 16'h3C00 + 16'(i * 7);
    endfunction

    // Timing tables in ns, modes 0..2
    int t_cyc [3] = '{480, 150, 120};
    int t_act [3] = '{215, 80, 70};
    int t_rr  [3] = '{50, 50, 25};
    int t_rw  [3] = '{215, 50, 25};
    int t_su  [3] = '{100, 30, 20};
    int t_wh  [3] = '{20, 15, 10};
    int t_ah  [3] = '{20, 5, 5};
    int t_sel [3] = '{50, 30, 25};
    int t_qr  [3] = '{120, 40, 35};
    int t_qw  [3] = '{40, 40, 35};

    function automatic int cd(int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- device-side monitor ----------------
    int cyc = 0;
    int nstrobe, ack_rises, lead, tail, wmin, wmax, gmin, gmax;
    int ack_t, low_t, rise_t, both_bad, dir_bad, oe_bad, cs_bad;
    bit first, cur_wr;
    logic ack_prev = 1'b1, s_prev = 1'b0, diow_prev = 1'b1;
    logic [15:0] last_dd;
    logic [15:0] wcap [16];

    assign dd_in = rpat(nstrobe);

    always @(negedge clk) begin
        logic s;
        cyc++;
        s = !dior_n || !diow_n;
        if (start) begin
            nstrobe = 0; ack_rises = 0; lead = -1; tail = -1;
            wmin = 1000000; wmax = 0; gmin = 1000000; gmax = 0;
            both_bad = 0; dir_bad = 0; oe_bad = 0; cs_bad = 0;
        end
        if (rst_n) begin
            if (cs_n !== 2'b11) cs_bad++;
            if (!dior_n && !diow_n) both_bad++;
            if ((!dior_n && cur_wr) || (!diow_n && !cur_wr)) dir_bad++;
            if (dd_oe && (dmack_n || !cur_wr)) oe_bad++;
            if (!dmack_n && ack_prev) begin ack_t = cyc; first = 1'b1; end
            if (dmack_n && !ack_prev) begin ack_rises++; tail = cyc - rise_t; end
            if (s && !s_prev) begin
                if (first) lead = cyc - ack_t;
                else begin
                    gmin = (cyc - rise_t < gmin) ? cyc - rise_t : gmin;
                    gmax = (cyc - rise_t > gmax) ? cyc - rise_t : gmax;
                end
                first = 1'b0;
                low_t = cyc;
            end
            if (!s && s_prev) begin
                wmin = (cyc - low_t < wmin) ? cyc - low_t : wmin;
                wmax = (cyc - low_t > wmax) ? cyc - low_t : wmax;
                rise_t = cyc;
                if (!diow_prev && nstrobe < 16) wcap[nstrobe] = last_dd;
                nstrobe++;
            end
            if (!diow_n) last_dd = dd_out;
        end
        ack_prev  = dmack_n;
        s_prev    = s;
        diow_prev = diow_n;
    end

    // ---------------- host buffer models ----------------
    int widx = 0;
    int rcnt = 0;
    logic [15:0] rcap [16];
    assign wr_data = wpat(widx);

    always @(posedge clk) begin
        if (start) begin
            widx <= 0;
            rcnt <= 0;
        end else begin
            if (wr_valid && wr_ready) widx <= widx + 1;
            if (rd_valid && rd_ready) begin
                if (rcnt < 16) rcap[rcnt] <= rd_data;
                rcnt <= rcnt + 1;
            end
        end
    end

    task automatic kick(int m, bit wr, int n);
        @(negedge clk);
        mode = 2'(m); dir_write = wr; word_count = 8'(n); cur_wr = wr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_data(bit wr, int n, string req);
        if (wr) begin
            chk(req, "words taken", widx, n);
            for (int i = 0; i < n; i++) chk(req, "write word", int'(wcap[i]), int'(wpat(i)));
        end else begin
            chk(req, "words delivered", rcnt, n);
            for (int i = 0; i < n; i++) chk(req, "read word", int'(rcap[i]), int'(rpat(i)));
        end
    endtask

    task automatic run(int m, bit wr, int n);
        int mm, act, pre_n, pre_f, rec, hold, gap;
        string rt;
        mm    = (m == 3) ? 0 : m;
        act   = cd(t_act[mm]);
        pre_n = wr ? cd(t_su[mm]) : 0;
        pre_f = wr ? mx(cd(t_sel[mm]), cd(t_su[mm])) : cd(t_sel[mm]);
        rec   = mx(mx(cd(wr ? t_rw[mm] : t_rr[mm]), cd(wr ? t_qw[mm] : t_qr[mm])),
                   mx(mx(cd(t_ah[mm]), wr ? cd(t_wh[mm]) : 1), cd(t_cyc[mm]) - act - pre_n));
        hold  = wr ? mx(cd(t_ah[mm]), cd(t_wh[mm])) : cd(t_ah[mm]);
        gap   = rec + pre_n;
        rt    = (m == 3) ? "R7" : "R2";
        kick(m, wr, n);
        wait_done();
        chk("R1", "strobe count", nstrobe, n);
        chk(rt, "min strobe width", wmin, act);
        chk(rt, "max strobe width", wmax, act);
        if (n > 1) begin
            chk(wr ? "R4" : "R3", "min gap", gmin, gap);
            chk(wr ? "R4" : "R3", "max gap", gmax, gap);
        end
        chk("R5", "ack to first strobe", lead, pre_f);
        chk("R6", "last strobe to ack release", tail, hold);
        chk("R10", "ack releases", ack_rises, 1);
        chk("R11", "overlap or wrong strobe", both_bad + dir_bad, 0);
        chk("R8", "output enable misuse", oe_bad, 0);
        chk("R12", "chip select not negated", cs_bad, 0);
        check_data(wr, n, wr ? "R8" : "R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "ack in reset", int'(dmack_n), 1);
        chk("R1", "strobes in reset", int'({dior_n, diow_n}), 3);
        chk("R1", "oe in reset", int'(dd_oe), 0);
        chk("R1", "rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: zero count is ignored
        kick(1, 1'b0, 0);
        repeat (5) @(negedge clk);
        chk("R1", "zero count busy", int'(busy), 0);
        chk("R1", "zero count ack", int'(dmack_n), 1);

        // Sweep: all mode codes, both directions, short and long transfers
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++) begin
                run(m, w[0], 1);
                run(m, w[0], 5);
            end

        // R10: request low at end of recovery pauses, then resumes
        kick(1, 1'b0, 6);
        while (nstrobe < 2) @(negedge clk);
        dmarq = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10", "ack released on pause", int'(dmack_n), 1);
        chk("R10", "no strobe during pause", nstrobe, 2);
        chk("R10", "still busy in pause", int'(busy), 1);
        dmarq = 1'b1;
        wait_done();
        chk("R10", "bursts after resume", ack_rises, 2);
        chk("R10", "resume setup lead", lead, cd(t_sel[1]));
        check_data(1'b0, 6, "R10");

        // R10: a short drop inside recovery is not seen
        kick(0, 1'b0, 3);
        while (nstrobe < 1) @(negedge clk);
        @(negedge clk);
        dmarq = 1'b0;
        repeat (2) @(negedge clk);
        dmarq = 1'b1;
        wait_done();
        chk("R10", "glitch ignored ack releases", ack_rises, 1);
        check_data(1'b0, 3, "R10");

        // R9: read back-pressure holds the next strobe
        rd_ready = 1'b0;
        kick(2, 1'b0, 3);
        repeat (40) @(negedge clk);
        chk("R9", "strobes while word pending", nstrobe, 1);
        chk("R9", "rd_valid held", int'(rd_valid), 1);
        chk("R9", "rd_data held", int'(rd_data), int'(rpat(0)));
        rd_ready = 1'b1;
        wait_done();
        check_data(1'b0, 3, "R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule